// File: doc/BRIEF.md
# Composite Sync Separator with Burst Gate

This block watches a composite sync line that is active low and already in step with the master clock. That clock runs at four times the colour subcarrier. The block counts the length of every low pulse in master-clock cycles and decides what kind of pulse it was. A pulse that returns high inside a per-standard acceptance window counts as line sync. A pulse that stays low past about half a line counts as broad (vertical) sync. Any other pulse counts as equalizing or serration and has no effect.

An accepted line sync produces a one-cycle line strobe. A fixed delay later it opens a burst-gate window of fixed length, and nothing else opens that window. While a pulse stays low past the broad threshold, the block holds a vertical flag high. The first broad pulse after a line sync (or after reset) raises a field strobe, and every second field also raises a frame strobe. The block also gives a copy of the sync input delayed by a fixed number of clocks. A level input selects the NTSC or PAL timing set, and all constants are cycle counts rounded to the nearest clock.

Top module: `sync_sep`

## Requirements
- R1: After a synchronous reset, line_stb, burst_gate, vsync, field_stb and frame_stb are 0 and sync_dly is 1.
- R2: A low pulse whose count of sampled-low cycles is inside the window (NTSC 58..77 inclusive, PAL 72..94 inclusive) raises line_stb for exactly one cycle. The strobe appears on the clock edge that first samples csync_n high again.
- R3: A low pulse whose count falls outside the window of the selected standard produces no line_stb and no burst_gate.
- R4: After an accepted line sync, burst_gate rises a fixed number of cycles after line_stb rose (NTSC 9, PAL 16) and stays high for a fixed number of cycles (NTSC 36, PAL 40).
- R5: std_ntsc high selects the NTSC constants and low selects the PAL constants. For example, a 90-cycle pulse is accepted under PAL and rejected under NTSC.
- R6: vsync is high on the edge that samples the low input for the broad-threshold time (NTSC 455 cycles, PAL 567 cycles). It stays high until the input is sampled high.
- R7: field_stb pulses for one cycle, together with the rise of vsync, on the first broad pulse after reset or after an accepted line sync. Later broad pulses before the next line sync give no strobe.
- R8: frame_stb pulses together with field_stb on the second, fourth and later even fields since reset, and stays 0 on odd fields.
- R9: The width counter saturates at 2047, so a pulse held low for longer than that is never accepted as line sync.
- R10: sync_dly reproduces csync_n delayed by 8 rising clock edges.
- R11: A falling edge of csync_n while burst_gate is high closes the gate on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at four times the subcarrier frequency |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | input | 1 | Composite sync, active low, synchronous to clk |
| std_ntsc | input | 1 | 1 selects NTSC timing, 0 selects PAL timing |
| line_stb | output | 1 | One-cycle strobe for an accepted line sync |
| burst_gate | output | 1 | Burst window after an accepted line sync |
| vsync | output | 1 | High while a broad pulse is in progress |
| field_stb | output | 1 | One-cycle strobe at the start of a field |
| frame_stb | output | 1 | One-cycle strobe at the start of every second field |
| sync_dly | output | 1 | Delayed copy of csync_n |

## Verification
The bench drives pulses exactly on both edges of the acceptance window and one cycle outside each edge. An off-by-one compare would then either drop a valid line or gate burst after an equalizing pulse. It times the start and length of the burst gate for both standards, and it re-runs a 90-cycle pulse under each standard. A design that ignored std_ntsc would accept or reject that pulse under both. It holds the line low long past the counter range, which catches a counter that wraps back into the line window. Finally it runs a sequence of broad pulses split by line syncs, which exposes a field strobe that repeats on every broad pulse or a frame parity that starts on the wrong field.

// File: rtl/sync_sep.sv
module sync_sep #(
  parameter int CNT_W    = 11,
  parameter int NT_HMIN  = 58,
  parameter int NT_HMAX  = 77,
  parameter int PL_HMIN  = 72,
  parameter int PL_HMAX  = 94,
  parameter int NT_BROAD = 455,
  parameter int PL_BROAD = 567,
  parameter int NT_BDLY  = 9,
  parameter int NT_BLEN  = 36,
  parameter int PL_BDLY  = 16,
  parameter int PL_BLEN  = 40,
  parameter int SYNC_DLY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n,
  input  logic std_ntsc,
  output logic line_stb,
  output logic burst_gate,
  output logic vsync,
  output logic field_stb,
  output logic frame_stb,
  output logic sync_dly
);

  localparam int NT_BTOT = NT_BDLY + NT_BLEN;
  localparam int PL_BTOT = PL_BDLY + PL_BLEN;
  localparam int BT_MAX  = (NT_BTOT > PL_BTOT) ? NT_BTOT : PL_BTOT;
  localparam int BT_W    = $clog2(BT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]    cnt, cnt_nx, hmin, hmax, brd;
  logic [BT_W-1:0]     bt, btot, blen;
  logic [SYNC_DLY-1:0] sr;
  logic in_vert, odd, accept, broad_hit, new_field;

  assign hmin = std_ntsc ? CNT_W'(NT_HMIN)  : CNT_W'(PL_HMIN);
  assign hmax = std_ntsc ? CNT_W'(NT_HMAX)  : CNT_W'(PL_HMAX);
  assign brd  = std_ntsc ? CNT_W'(NT_BROAD) : CNT_W'(PL_BROAD);
  assign btot = std_ntsc ? BT_W'(NT_BTOT)   : BT_W'(PL_BTOT);
  assign blen = std_ntsc ? BT_W'(NT_BLEN)   : BT_W'(PL_BLEN);

  assign cnt_nx    = csync_n ? '0 : ((cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1));
  assign accept    = csync_n && (cnt >= hmin) && (cnt <= hmax);
  assign broad_hit = !csync_n && (cnt_nx == brd);
  assign new_field = broad_hit && !in_vert;

  assign burst_gate = (bt != '0) && (bt <= blen);
  assign sync_dly   = sr[SYNC_DLY-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      bt        <= '0;
      line_stb  <= 1'b0;
      vsync     <= 1'b0;
      field_stb <= 1'b0;
      frame_stb <= 1'b0;
      in_vert   <= 1'b0;
      odd       <= 1'b0;
      sr        <= '1;
    end else begin
      cnt       <= cnt_nx;
      line_stb  <= accept;
      vsync     <= !csync_n && (cnt_nx >= brd);
      field_stb <= new_field;
      frame_stb <= new_field && odd;
      sr        <= {sr[SYNC_DLY-2:0], csync_n};
      if (new_field) odd <= !odd;
      if (broad_hit) in_vert <= 1'b1;
      else if (accept) in_vert <= 1'b0;
      if (accept) bt <= btot;
      else if (!csync_n) bt <= '0;
      else if (bt != '0) bt <= bt - BT_W'(1);
    end
  end

  p_line_single_r2: assert property (@(posedge clk) disable iff (rst)
    line_stb |=> !line_stb);

  p_gate_not_in_sync_r11: assert property (@(posedge clk) disable iff (rst)
    burst_gate |-> $past(csync_n));

  p_field_with_vsync_r7: assert property (@(posedge clk) disable iff (rst)
    field_stb |-> vsync);

  p_frame_with_field_r8: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> field_stb);

  p_cnt_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (!csync_n && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  p_vsync_low_only_r6: assert property (@(posedge clk) disable iff (rst)
    vsync |-> !$past(csync_n));

endmodule

// File: tb/sync_sep_tb.sv
module sync_sep_tb_top;
  logic clk = 1'b0, rst = 1'b1, csync_n = 1'b1, std_ntsc = 1'b1;
  logic line_stb, burst_gate, vsync, field_stb, frame_stb, sync_dly;
  int checks = 0, failures = 0;
  int gate_cyc = 0, line_cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_sep dut_i (.clk(clk), .rst(rst), .csync_n(csync_n), .std_ntsc(std_ntsc),
    .line_stb(line_stb), .burst_gate(burst_gate), .vsync(vsync),
    .field_stb(field_stb), .frame_stb(frame_stb), .sync_dly(sync_dly));

  always @(posedge clk) begin
    if (burst_gate) gate_cyc <= gate_cyc + 1;
    if (line_stb)   line_cyc <= line_cyc + 1;
  end

  task automatic tick; @(negedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1; csync_n = 1'b1;
    repeat (3) tick;
    rst = 1'b0;
    tick;
  endtask

  // Drives a low pulse of w sampled cycles; checks acceptance, burst delay d and length l.
  task automatic line_pulse(input int w, input bit acc, input int d, input int l, input string req);
    int g0, l0, k, len;
    g0 = gate_cyc; l0 = line_cyc;
    csync_n = 1'b0;
    repeat (w) tick;
    csync_n = 1'b1;
    tick;
    chk(line_stb == acc, req, line_stb, acc);
    if (acc) begin
      k = 0;
      while (!burst_gate && k < d + 10) begin tick; k++; end
      chk(k == d, {req, " burst delay R4"}, k, d);
      len = 0;
      while (burst_gate && len < l + 10) begin tick; len++; end
      chk(len == l, {req, " burst length R4"}, len, l);
      repeat (20) tick;
    end else begin
      repeat (80) tick;
      chk(gate_cyc == g0 && line_cyc == l0, {req, " no burst R3"}, gate_cyc - g0, 0);
    end
  endtask

  task automatic t_reset;
    do_reset;
    chk({line_stb, burst_gate, vsync, field_stb, frame_stb} == 5'b0, "R1 outputs", 
        {line_stb, burst_gate, vsync, field_stb, frame_stb}, 0);
    chk(sync_dly == 1'b1, "R1 sync_dly", sync_dly, 1);
  endtask

  task automatic t_window;
    do_reset; std_ntsc = 1'b1;
    line_pulse(65, 1, 9, 36, "R2 ntsc 65");
    line_pulse(58, 1, 9, 36, "R2 ntsc min 58");
    line_pulse(77, 1, 9, 36, "R2 ntsc max 77");
    line_pulse(57, 0, 0, 0, "R3 ntsc 57");
    line_pulse(78, 0, 0, 0, "R3 ntsc 78");
    line_pulse(8,  0, 0, 0, "R3 ntsc equalizing 8");
  endtask

  task automatic t_standard;
    do_reset; std_ntsc = 1'b0; tick;
    line_pulse(90, 1, 16, 40, "R5 pal 90");
    line_pulse(72, 1, 16, 40, "R2 pal min 72");
    line_pulse(94, 1, 16, 40, "R2 pal max 94");
    line_pulse(95, 0, 0, 0, "R3 pal 95");
    line_pulse(71, 0, 0, 0, "R3 pal 71");
    std_ntsc = 1'b1; tick;
    line_pulse(90, 0, 0, 0, "R5 ntsc 90");
  endtask

  task automatic broad(input int brd, input bit f, input bit fr, input string req);
    csync_n = 1'b0;
    repeat (brd - 1) tick;
    chk(vsync == 1'b0, {req, " vsync early R6"}, vsync, 0);
    tick;
    chk(vsync == 1'b1, {req, " vsync R6"}, vsync, 1);
    chk(field_stb == f, {req, " field R7"}, field_stb, f);
    chk(frame_stb == fr, {req, " frame R8"}, frame_stb, fr);
    tick;
    chk(field_stb == 1'b0 && frame_stb == 1'b0, {req, " strobe width R7"}, field_stb, 0);
    repeat (30) tick;
    csync_n = 1'b1;
    tick;
    chk(line_stb == 1'b0 && vsync == 1'b0, {req, " broad release R6"}, {line_stb, vsync}, 0);
    repeat (40) tick;
  endtask

  task automatic t_fields;
    do_reset; std_ntsc = 1'b1; tick;
    broad(455, 1, 0, "field1");
    broad(455, 0, 0, "repeat broad");
    line_pulse(65, 1, 9, 36, "R2 between fields");
    broad(455, 1, 1, "field2");
    line_pulse(65, 1, 9, 36, "R2 between fields b");
    broad(455, 1, 0, "field3");
    std_ntsc = 1'b0; tick;
    line_pulse(80, 1, 16, 40, "R2 pal line");
    broad(567, 1, 1, "pal field4");
  endtask

  task automatic t_saturate;
    do_reset; std_ntsc = 1'b1; tick;
    line_pulse(2100, 0, 0, 0, "R9 stuck low 2100");
    line_pulse(2048 + 65, 0, 0, 0, "R9 wrap 2113");
    line_pulse(65, 1, 9, 36, "R9 recovery");
  endtask

  task automatic t_delay;
    do_reset;
    csync_n = 1'b0;
    repeat (7) tick;
    chk(sync_dly == 1'b1, "R10 before delay", sync_dly, 1);
    tick;
    chk(sync_dly == 1'b0, "R10 at delay", sync_dly, 0);
    csync_n = 1'b1;
    repeat (8) tick;
    chk(sync_dly == 1'b1, "R10 release", sync_dly, 1);
  endtask

  task automatic t_cut;
    do_reset; std_ntsc = 1'b1; tick;
    csync_n = 1'b0; repeat (65) tick; csync_n = 1'b1; tick;
    repeat (9 + 5) tick;
    chk(burst_gate == 1'b1, "R11 gate open", burst_gate, 1);
    csync_n = 1'b0; tick;
    chk(burst_gate == 1'b0, "R11 gate cut", burst_gate, 0);
    repeat (64) tick; csync_n = 1'b1; tick;
    chk(line_stb == 1'b1, "R11 next line", line_stb, 1);
    repeat (60) tick;
  endtask

  initial begin
    t_reset;
    t_window;
    t_standard;
    t_fields;
    t_saturate;
    t_delay;
    t_cut;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule